// File: doc/BRIEF.md
# Control-Line Handshake Logic for a Parallel Port

This block holds the control register of one side of a parallel peripheral port, along with the logic for that side's two control lines. Line C1 is an input only. Line C2 is either an input or an output. An active transition on either line sets an interrupt flag. The block pulls an active-low interrupt request low when a set flag has its enable bit set. When C2 is an output, it can act as a read strobe that is released by C1 or by the next bus cycle, or it can hold a fixed level. A processor read of the peripheral data register clears both flags. The port data registers and the address decoder sit outside this block.

The bus is sampled once per enable-clock period. The one-cycle pulse `e_tick` marks the falling enable edge that completes a bus cycle, and all register accesses take effect in that cycle. The control lines pass through a configurable synchronizer before edge detection. For `SYNC_STAGES` cycles plus one after reset, no edges are reported, so that settling inputs raise no false flags.

The C2 driver is a state machine with six named states:

- LISTEN: C2 is an input.
- READY: strobe armed, C2 high.
- HOLD: C2 low until C1 acts.
- PULSE: C2 low for one enable period.
- FORCE_LO: C2 held low.
- FORCE_HI: C2 held high.

The transitions are:

- From LISTEN, FORCE_LO and FORCE_HI, the machine moves to the home state of the current mode.
- READY goes to HOLD (mode 100) or to PULSE (mode 101) on a peripheral read.
- HOLD returns to READY on an active C1 edge.
- PULSE returns to READY on the next `e_tick`.
- Any strobe state whose mode no longer matches moves to the home state of the new mode.

Top module: `pia_ctl_handshake`

## Requirements
- R1: After reset the control register reads 0x00, `irq_n` is high, `c2_oe` is low and `sel_periph` is low.
- R2: A control write (`cs`=1, `reg_sel`=1, `rw`=0 at `e_tick`) loads bits 5:0 from `wdata[5:0]`; bits 7:6 ignore the write and read back as the C1 and C2 flags.
- R3: Bit 7 sets on a C1 edge chosen by bit 1 (0 falling, 1 rising); the other edge leaves it clear.
- R4: Bit 6 sets on a C2 edge chosen by bit 4 (0 falling, 1 rising), but only while bit 5 is 0; in output modes C2 transitions leave it clear.
- R5: A read with `cs`=1, `reg_sel`=0, `rw`=1 at `e_tick` clears bits 7 and 6 when bit 2 is 1; with bit 2 at 0 (direction register selected) the flags stay set. A flag edge in the same cycle wins over the clear.
- R6: `irq_n` is low exactly when (bit 7 and bit 0) or (bit 6 and bit 3 and bit 5 is 0).
- R7: In mode 101 (bits 5:3), C2 goes low with the peripheral read's enable edge and returns high at the next `e_tick`.
- R8: In mode 100, C2 goes low with the peripheral read's enable edge and stays low through later enable periods until the next active C1 edge.
- R9: Mode 110 drives C2 low and mode 111 drives it high. In modes 10x, C2 is high while no strobe is pending. `c2_oe` is high in all modes with bit 5 set. A control-register read does not start a strobe.
- R10: `sel_periph` follows bit 2 (1 selects the peripheral register, 0 the direction register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| e_tick | input | 1 | One-cycle pulse marking the end of a bus cycle |
| cs | input | 1 | Port selected for this bus cycle |
| reg_sel | input | 1 | 1 = control register, 0 = data/direction register |
| rw | input | 1 | 1 = read, 0 = write |
| wdata | input | 8 | Write data |
| ctrl_rdata | output | 8 | Control register read value {C1 flag, C2 flag, config[5:0]} |
| sel_periph | output | 1 | Paired address maps the peripheral register |
| c1_in | input | 1 | Control line C1 |
| c2_in | input | 1 | Control line C2 as seen at the pin |
| c2_out | output | 1 | C2 drive level |
| c2_oe | output | 1 | C2 output enable |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench goes after the following corner cases:

- **Edge polarity.** Each polarity is driven in both directions. A design with an inverted polarity bit would set a flag on the wrong transition and miss the right one.
- **C2 in output mode.** The bench toggles the C2 pin while C2 is an output. A design that keeps watching the pin would raise a spurious flag and interrupt.
- **Read clearing.** It reads the direction register and checks that the flags survive. A decoder that ignores bit 2 would clear them silently.
- **Strobe release.** It checks both release conditions. A pulse that is not released would hold C2 low. A held strobe that is released by the bus clock instead of by C1 would return high too early.
- **Control-register reads.** A control-register read must not start a strobe.

// File: rtl/pia_hs_pkg.sv
package pia_hs_pkg;

    localparam int CFG_W = 6;

    localparam int B_C1_EN   = 0;
    localparam int B_C1_RISE = 1;
    localparam int B_PSEL    = 2;
    localparam int B_C2_EN   = 3;
    localparam int B_C2_RISE = 4;
    localparam int B_C2_OUT  = 5;

    typedef enum logic [2:0] {
        C2S_LISTEN   = 3'd0,
        C2S_READY    = 3'd1,
        C2S_HOLD     = 3'd2,
        C2S_PULSE    = 3'd3,
        C2S_FORCE_LO = 3'd4,
        C2S_FORCE_HI = 3'd5
    } c2_state_e;

    function automatic c2_state_e home_state(input logic [2:0] mode);
        c2_state_e s;
        if (!mode[2])
            s = C2S_LISTEN;
        else if (!mode[1])
            s = C2S_READY;
        else if (!mode[0])
            s = C2S_FORCE_LO;
        else
            s = C2S_FORCE_HI;
        return s;
    endfunction

endpackage

// File: rtl/hs_line_sync.sv
module hs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    localparam int WARM_MAX = STAGES + 1;
    localparam int WARM_W   = $clog2(WARM_MAX + 1);

    logic              lvl;
    logic              prev_q;
    logic [WARM_W-1:0] warm_q;
    logic              armed;

    generate
        if (STAGES == 0) begin : g_direct
            assign lvl = din;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= '1;
                end else begin
                    chain_q[0] <= din;
                    for (int i = 1; i < STAGES; i++) begin
                        chain_q[i] <= chain_q[i-1];
                    end
                end
            end
            assign lvl = chain_q[STAGES-1];
        end
    endgenerate

    assign armed = (warm_q == WARM_W'(WARM_MAX));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            warm_q <= '0;
        end else begin
            prev_q <= lvl;
            if (!armed)
                warm_q <= warm_q + 1'b1;
        end
    end

    assign rise = armed &  lvl & ~prev_q;
    assign fall = armed & ~lvl &  prev_q;

endmodule

// File: rtl/hs_ctrl_reg.sv
module hs_ctrl_reg
    import pia_hs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_cfg,
    input  logic             clr_flags,
    input  logic             c1_hit,
    input  logic             c2_hit,
    output logic [CFG_W-1:0] cfg,
    output logic             flag_c1,
    output logic             flag_c2
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            cfg <= wr_cfg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_c1 <= 1'b0;
            flag_c2 <= 1'b0;
        end else begin
            if (c1_hit)
                flag_c1 <= 1'b1;
            else if (clr_flags)
                flag_c1 <= 1'b0;
            if (c2_hit)
                flag_c2 <= 1'b1;
            else if (clr_flags)
                flag_c2 <= 1'b0;
        end
    end

endmodule

// File: rtl/hs_c2_fsm.sv
module hs_c2_fsm
    import pia_hs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    input  logic       e_tick,
    input  logic       periph_rd,
    input  logic       c1_hit,
    output logic       c2_out,
    output logic       c2_oe
);
    c2_state_e state_q;
    c2_state_e state_d;
    c2_state_e home;

    assign home = home_state(mode);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C2S_LISTEN, C2S_FORCE_LO, C2S_FORCE_HI: begin
                state_d = home;
            end
            C2S_READY: begin
                if (mode[2:1] != 2'b10)
                    state_d = home;
                else if (periph_rd)
                    state_d = mode[0] ? C2S_PULSE : C2S_HOLD;
            end
            C2S_HOLD: begin
                if (mode != 3'b100)
                    state_d = home;
                else if (c1_hit)
                    state_d = C2S_READY;
            end
            C2S_PULSE: begin
                if (mode != 3'b101)
                    state_d = home;
                else if (e_tick)
                    state_d = C2S_READY;
            end
            default: state_d = C2S_LISTEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= C2S_LISTEN;
        else
            state_q <= state_d;
    end

    always_comb begin
        c2_out = 1'b1;
        c2_oe  = 1'b1;
        unique case (state_q)
            C2S_LISTEN:   c2_oe  = 1'b0;
            C2S_READY:    c2_out = 1'b1;
            C2S_HOLD:     c2_out = 1'b0;
            C2S_PULSE:    c2_out = 1'b0;
            C2S_FORCE_LO: c2_out = 1'b0;
            C2S_FORCE_HI: c2_out = 1'b1;
            default:      c2_oe  = 1'b0;
        endcase
    end

endmodule

// File: rtl/pia_ctl_handshake.sv
module pia_ctl_handshake
    import pia_hs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       e_tick,
    input  logic       cs,
    input  logic       reg_sel,
    input  logic       rw,
    input  logic [7:0] wdata,
    output logic [7:0] ctrl_rdata,
    output logic       sel_periph,
    input  logic       c1_in,
    input  logic       c2_in,
    output logic       c2_out,
    output logic       c2_oe,
    output logic       irq_n
);
    logic [CFG_W-1:0] cfg;
    logic flag_c1, flag_c2;
    logic c1_rise, c1_fall, c2_rise, c2_fall;
    logic c1_hit, c2_hit;
    logic ctrl_wr, periph_rd;
    logic unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[7:6];

    assign ctrl_wr   = e_tick & cs &  reg_sel & ~rw;
    assign periph_rd = e_tick & cs & ~reg_sel &  rw & cfg[B_PSEL];

    hs_line_sync #(.STAGES(SYNC_STAGES)) u_sync_c1 (
        .clk (clk),
        .rst_n (rst_n),
        .din (c1_in),
        .rise (c1_rise),
        .fall (c1_fall)
    );

    hs_line_sync #(.STAGES(SYNC_STAGES)) u_sync_c2 (
        .clk (clk),
        .rst_n (rst_n),
        .din (c2_in),
        .rise (c2_rise),
        .fall (c2_fall)
    );

    assign c1_hit = cfg[B_C1_RISE] ? c1_rise : c1_fall;
    assign c2_hit = ~cfg[B_C2_OUT] & (cfg[B_C2_RISE] ? c2_rise : c2_fall);

    hs_ctrl_reg u_reg (
        .clk (clk),
        .rst_n (rst_n),
        .wr_en (ctrl_wr),
        .wr_cfg (wdata[CFG_W-1:0]),
        .clr_flags (periph_rd),
        .c1_hit (c1_hit),
        .c2_hit (c2_hit),
        .cfg (cfg),
        .flag_c1 (flag_c1),
        .flag_c2 (flag_c2)
    );

    hs_c2_fsm u_fsm (
        .clk (clk),
        .rst_n (rst_n),
        .mode (cfg[B_C2_OUT:B_C2_EN]),
        .e_tick (e_tick),
        .periph_rd (periph_rd),
        .c1_hit (c1_hit),
        .c2_out (c2_out),
        .c2_oe (c2_oe)
    );

    assign ctrl_rdata = {flag_c1, flag_c2, cfg};
    assign sel_periph = cfg[B_PSEL];
    assign irq_n = ~((flag_c1 & cfg[B_C1_EN]) |
                     (flag_c2 & cfg[B_C2_EN] & ~cfg[B_C2_OUT]));

endmodule

// File: rtl/pia_ctl_handshake_chk.sv
module pia_ctl_handshake_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       e_tick,
    input logic       cs,
    input logic       reg_sel,
    input logic       rw,
    input logic [5:0] wdata_lo,
    input logic [7:0] ctrl_rdata,
    input logic       c2_out,
    input logic       c2_oe,
    input logic       irq_n,
    input logic       periph_rd,
    input logic       c1_hit
);
    // R2
    cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (e_tick && cs && reg_sel && !rw) |=> (ctrl_rdata[5:0] == $past(wdata_lo)));

    // R5
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_rd && !c1_hit) |=> !ctrl_rdata[7]);

    // R4
    c2_flag_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata[5] |=> !$rose(ctrl_rdata[6]));

    // R6
    irq_c1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata[7] && ctrl_rdata[0]) |-> !irq_n);

    // R7
    pulse_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c2_oe && !c2_out && ctrl_rdata[5:3] == 3'b101 && e_tick) |=> c2_out);

    // R9
    force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl_rdata[5:3]) == 3'b111 && ctrl_rdata[5:3] == 3'b111) |-> (c2_oe && c2_out));

endmodule

bind pia_ctl_handshake pia_ctl_handshake_chk chk_i (
    .clk (clk),
    .rst_n (rst_n),
    .e_tick (e_tick),
    .cs (cs),
    .reg_sel (reg_sel),
    .rw (rw),
    .wdata_lo (wdata[5:0]),
    .ctrl_rdata (ctrl_rdata),
    .c2_out (c2_out),
    .c2_oe (c2_oe),
    .irq_n (irq_n),
    .periph_rd (periph_rd),
    .c1_hit (c1_hit)
);

// File: tb/pia_ctl_handshake_tb_top.sv
module pia_ctl_handshake_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       e_tick = 1'b0;
    logic       cs = 1'b0;
    logic       reg_sel = 1'b0;
    logic       rw = 1'b1;
    logic [7:0] wdata = 8'h00;
    logic [7:0] ctrl_rdata;
    logic       sel_periph;
    logic       c1_in = 1'b1;
    logic       c2_in = 1'b1;
    logic       c2_out;
    logic       c2_oe;
    logic       irq_n;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pia_ctl_handshake dut_i (
        .clk (clk),
        .rst_n (rst_n),
        .e_tick (e_tick),
        .cs (cs),
        .reg_sel (reg_sel),
        .rw (rw),
        .wdata (wdata),
        .ctrl_rdata (ctrl_rdata),
        .sel_periph (sel_periph),
        .c1_in (c1_in),
        .c2_in (c2_in),
        .c2_out (c2_out),
        .c2_oe (c2_oe),
        .irq_n (irq_n)
    );

    // {cfg[7:0], c1 start, c1 end, c2 start, c2 end, exp bit7, exp bit6, exp irq_n}
    localparam int NVEC = 13;
    localparam logic [14:0] VEC [0:NVEC-1] = '{
        {8'h04, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
        {8'h05, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'h05, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
        {8'h07, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'h07, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
        {8'h06, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
        {8'h05, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
        {8'h0C, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        {8'h1C, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        {8'h1C, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        {8'h14, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
        {8'h3C, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        {8'h0D, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus(input logic sel, input logic en, input logic rd, input logic [7:0] d);
        @(negedge clk);
        cs = en; reg_sel = sel; rw = rd; wdata = d; e_tick = 1'b1;
        @(negedge clk);
        e_tick = 1'b0; cs = 1'b0; rw = 1'b1;
    endtask

    task automatic wr_cfg(input logic [7:0] d);
        bus(1'b1, 1'b1, 1'b0, d);
    endtask

    task automatic rd_data();
        bus(1'b0, 1'b1, 1'b1, 8'h00);
    endtask

    task automatic idle_tick();
        bus(1'b0, 1'b0, 1'b1, 8'h00);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        clks(4);
        // R1 reset state
        check(ctrl_rdata == 8'h00, "R1 ctrl", ctrl_rdata, 0);
        check(irq_n == 1'b1, "R1 irq_n", irq_n, 1);
        check(c2_oe == 1'b0, "R1 c2_oe", c2_oe, 0);
        check(sel_periph == 1'b0, "R10 sel_periph reset", sel_periph, 0);
        rst_n = 1'b1;
        clks(8);

        // R2 bits 7:6 ignore writes
        wr_cfg(8'hC4);
        check(ctrl_rdata == 8'h04, "R2 read-only flags", ctrl_rdata, 8'h04);
        check(sel_periph == 1'b1, "R10 sel_periph set", sel_periph, 1);

        // vector table: R3 R4 R5 R6
        for (int i = 0; i < NVEC; i++) begin
            logic [14:0] v;
            v = VEC[i];
            c1_in = v[6]; c2_in = v[4];
            wr_cfg(v[14:7]);
            clks(6);
            rd_data();
            clks(2);
            c1_in = v[5]; c2_in = v[3];
            clks(6);
            check(ctrl_rdata[7] == v[2], "R3 c1 flag", ctrl_rdata[7], v[2]);
            check(ctrl_rdata[6] == v[1], "R4 c2 flag", ctrl_rdata[6], v[1]);
            check(ctrl_rdata[5:0] == v[12:7], "R2 cfg readback", ctrl_rdata[5:0], v[12:7]);
            check(irq_n == v[0], "R6 irq_n", irq_n, v[0]);
        end

        // R5 direction-register read keeps flags
        c1_in = 1'b1; c2_in = 1'b1;
        wr_cfg(8'h01);
        clks(6);
        check(sel_periph == 1'b0, "R10 sel_periph clear", sel_periph, 0);
        rd_data();
        clks(2);
        c1_in = 1'b0;
        clks(6);
        check(ctrl_rdata[7] == 1'b1 && irq_n == 1'b0, "R3 flag before ddr read", ctrl_rdata, 8'h81);
        rd_data();
        clks(2);
        check(ctrl_rdata[7] == 1'b1, "R5 ddr read keeps flag", ctrl_rdata[7], 1);
        wr_cfg(8'h05);
        rd_data();
        clks(1);
        check(ctrl_rdata[7] == 1'b0 && irq_n == 1'b1, "R5 periph read clears", ctrl_rdata, 8'h05);
        c1_in = 1'b1;
        clks(6);

        // R9 / R7 pulse strobe mode 101
        wr_cfg(8'h2C);
        clks(3);
        check(c2_oe == 1'b1 && c2_out == 1'b1, "R9 strobe idle high", {c2_oe, c2_out}, 3);
        bus(1'b1, 1'b1, 1'b1, 8'h00);
        clks(2);
        check(c2_out == 1'b1, "R9 ctrl read no strobe", c2_out, 1);
        rd_data();
        check(c2_out == 1'b0, "R7 pulse low", c2_out, 0);
        idle_tick();
        check(c2_out == 1'b1, "R7 pulse released", c2_out, 1);

        // R8 held strobe mode 100, C1 falling releases
        wr_cfg(8'h24);
        clks(3);
        rd_data();
        check(c2_out == 1'b0, "R8 hold low", c2_out, 0);
        idle_tick();
        idle_tick();
        check(c2_out == 1'b0, "R8 still low after ticks", c2_out, 0);
        c1_in = 1'b0;
        clks(6);
        check(c2_out == 1'b1, "R8 released by C1", c2_out, 1);
        check(ctrl_rdata[7] == 1'b1, "R3 flag on release edge", ctrl_rdata[7], 1);
        c1_in = 1'b1;

        // R9 fixed levels
        wr_cfg(8'h34);
        clks(3);
        check(c2_oe == 1'b1 && c2_out == 1'b0, "R9 force low", {c2_oe, c2_out}, 2);
        wr_cfg(8'h3C);
        clks(3);
        check(c2_oe == 1'b1 && c2_out == 1'b1, "R9 force high", {c2_oe, c2_out}, 3);
        wr_cfg(8'h04);
        clks(3);
        check(c2_oe == 1'b0, "R9 back to input", c2_oe, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule